// File: doc/BRIEF.md
# Stack-VM Instruction Decode and Legality Check

The block takes one 64-bit instruction word of a register-less stack virtual machine, together with a 2-bit extension selector, and turns it into registered control fields for an execute stage: three signed operand offsets, the two base-register selects, the operand-1 source, the result logic, the PC and AP update modes, the opcode, the extension and the instruction length in words. It fetches nothing and computes no operand values. Its only task is to split the word into fields and check them.

Each decode also checks the word against the encoding rules. These cover the reserved top bit, the sparse legal codes of each flag group, the immediate-operand form, the fixed shapes of call and return, and the limits that each extension places on the other fields. A word that breaks any rule comes out flagged invalid, with a 4-bit cause. When a word breaks several rules, the cause names the first failed rule in a fixed priority order.

Words enter on a valid/ready handshake. The decode appears one cycle after acceptance and stays unchanged until the consumer takes it. The upstream side can be accepted in the same cycle that the consumer drains the previous result.

Top module: `vm_insn_check`

## Requirements
- R1: Bits [15:0], [31:16] and [47:32] hold the destination, first-operand and second-operand offsets in biased form. Each output offset is the field value minus 32768, as a 16-bit two's-complement number.
- R2: Bit 48 selects the destination base and bit 49 the first-operand base (0 = AP, 1 = FP). The operand-1 source (bits 52:50), result logic (54:53), PC update (57:55), AP update (59:58) and opcode (62:60) appear unchanged at the outputs, and so does the extension selector.
- R3: The instruction size output is 2 when the operand-1 source is 1 (pc-relative immediate) and 1 otherwise.
- R4: When bit 63 is set, the word is invalid with cause 1, whatever else is wrong with it.
- R5: Illegal field codes give the following causes, checked in this order. Operand-1 source not in {0,1,2,4} gives 2. Result logic 3 gives 3. PC update not in {0,1,2,4} gives 4. AP update 3 gives 5. Opcode not in {0,1,2,4} gives 6.
- R6: With all codes legal, an operand-1 source of 1 whose second offset is not +1 gives cause 7.
- R7: Opcode 1 (call) requires a destination offset of 0 on AP, a first-operand offset of +1 on AP and an AP update of 0. Otherwise the cause is 8.
- R8: Opcode 2 (return) requires a destination offset of −2 on FP, a second offset of −1 with operand-1 source 2, result logic 0 and PC update 1. Otherwise the cause is 9.
- R9: Extension 1 or 2 requires opcode 0, operand-1 source 2 or 4, result logic 0, PC update 0 and AP update 0 or 2. Otherwise the cause is 10.
- R10: Extension 3 requires result logic 1 or 2, operand-1 source other than 0, PC update 0 and AP update 0 or 2. Otherwise the cause is 11. Extension 0 adds no rule.
- R11: The invalid flag is set exactly when the cause is non-zero. A word that passes every rule has cause 0.
- R12: in_ready is high when no result is held or the held result is being taken. An accepted word appears at the outputs on the next cycle. A held result stays unchanged while out_ready is low.
- R13: While reset is asserted, and until it has been released for two clock edges, out_valid and in_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Decoder can accept a word |
| in_word | input | 64 | Raw instruction word |
| in_ext | input | 2 | Extension selector |
| out_valid | output | 1 | Decode result held |
| out_ready | input | 1 | Consumer takes the result |
| out_off_dst | output | 16 | Signed destination offset |
| out_off_op0 | output | 16 | Signed first-operand offset |
| out_off_op1 | output | 16 | Signed second-operand offset |
| out_dst_fp | output | 1 | Destination base is FP |
| out_op0_fp | output | 1 | First-operand base is FP |
| out_op1_src | output | 3 | Operand-1 source code |
| out_res_logic | output | 2 | Result logic code |
| out_pc_upd | output | 3 | PC update code |
| out_ap_upd | output | 2 | AP update code |
| out_opcode | output | 3 | Opcode |
| out_ext | output | 2 | Extension selector |
| out_size | output | 2 | Instruction size in words |
| out_invalid | output | 1 | Word breaks a rule |
| out_reason | output | 4 | Cause of the first failed rule |

## Verification
Two things can fall in the same cycle. A word can break several rules at once, and a new word can be accepted in the same cycle that the consumer drains the held one. The bench builds words that break a high- and a low-priority rule together, such as reserved bit plus a bad source code, an immediate fault inside a malformed call, or an illegal opcode under extension 3. It expects the higher cause. It also drives back-to-back words with out_ready high while a result is held, and stalls with a new word waiting. A behavioural model, advanced once per clock, judges every output field and in_ready on each cycle.

// File: rtl/vm_dec_pkg.sv
`timescale 1ns/1ps
package vm_dec_pkg;
  localparam int unsigned OFF_W    = 16;
  localparam int unsigned N_OFF    = 3;
  localparam int unsigned FLAG_LSB = N_OFF * OFF_W;
  localparam int unsigned WORD_W   = FLAG_LSB + 16;
  localparam int unsigned EXT_W    = 2;
  localparam int unsigned RSN_W    = 4;
  localparam int unsigned DREG_BIT = FLAG_LSB;
  localparam int unsigned AREG_BIT = FLAG_LSB + 1;
  localparam int unsigned SRC_LSB  = FLAG_LSB + 2;
  localparam int unsigned RES_LSB  = FLAG_LSB + 5;
  localparam int unsigned PCU_LSB  = FLAG_LSB + 7;
  localparam int unsigned APU_LSB  = FLAG_LSB + 10;
  localparam int unsigned OPC_LSB  = FLAG_LSB + 12;
  localparam int unsigned RSVD_BIT = WORD_W - 1;

  typedef enum logic [RSN_W-1:0] {
    RSN_OK     = 4'd0,
    RSN_RSVD   = 4'd1,
    RSN_SRC    = 4'd2,
    RSN_RES    = 4'd3,
    RSN_PCU    = 4'd4,
    RSN_APU    = 4'd5,
    RSN_OPC    = 4'd6,
    RSN_IMM    = 4'd7,
    RSN_CALL   = 4'd8,
    RSN_RET    = 4'd9,
    RSN_HASH   = 4'd10,
    RSN_XARITH = 4'd11
  } reason_e;

  typedef struct packed {
    logic [OFF_W-1:0] off_dst;
    logic [OFF_W-1:0] off_op0;
    logic [OFF_W-1:0] off_op1;
    logic             dst_fp;
    logic             op0_fp;
    logic [2:0]       op1_src;
    logic [1:0]       res_logic;
    logic [2:0]       pc_upd;
    logic [1:0]       ap_upd;
    logic [2:0]       opcode;
    logic [EXT_W-1:0] ext;
    logic [1:0]       size;
    logic             invalid;
    reason_e          reason;
  } dec_t;
endpackage

// File: rtl/vm_rst_sync.sv
`timescale 1ns/1ps
module vm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/vm_dec_fields.sv
`timescale 1ns/1ps
module vm_dec_fields
  import vm_dec_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [EXT_W-1:0]  ext,
  output dec_t              fld
);
  localparam logic [OFF_W-1:0] BIAS = OFF_W'(1) << (OFF_W - 1);

  logic [OFF_W-1:0] offs [N_OFF];

  for (genvar k = 0; k < N_OFF; k++) begin : g_off
    assign offs[k] = word[k*OFF_W +: OFF_W] ^ BIAS;
  end

  always_comb begin
    fld           = '0;
    fld.off_dst   = offs[0];
    fld.off_op0   = offs[1];
    fld.off_op1   = offs[2];
    fld.dst_fp    = word[DREG_BIT];
    fld.op0_fp    = word[AREG_BIT];
    fld.op1_src   = word[SRC_LSB +: 3];
    fld.res_logic = word[RES_LSB +: 2];
    fld.pc_upd    = word[PCU_LSB +: 3];
    fld.ap_upd    = word[APU_LSB +: 2];
    fld.opcode    = word[OPC_LSB +: 3];
    fld.ext       = ext;
    fld.size      = (word[SRC_LSB +: 3] == 3'd1) ? 2'd2 : 2'd1;
    fld.invalid   = 1'b0;
    fld.reason    = RSN_OK;
  end
endmodule

// File: rtl/vm_dec_rules.sv
`timescale 1ns/1ps
module vm_dec_rules
  import vm_dec_pkg::*;
(
  input  logic    rsvd,
  input  dec_t    fld,
  output reason_e reason
);
  localparam logic [OFF_W-1:0] OFF_ZERO = '0;
  localparam logic [OFF_W-1:0] OFF_ONE  = OFF_W'(1);
  localparam logic [OFF_W-1:0] OFF_NEG1 = '1;
  localparam logic [OFF_W-1:0] OFF_NEG2 = ~OFF_W'(1);
  localparam logic [EXT_W-1:0] EXT_HASH = EXT_W'(1);
  localparam logic [EXT_W-1:0] EXT_HFIN = EXT_W'(2);
  localparam logic [EXT_W-1:0] EXT_XAR  = EXT_W'(3);

  logic src_ok, res_ok, pcu_ok, apu_ok, opc_ok;
  logic imm_ok, call_ok, ret_ok, hash_ok, xar_ok;
  logic ap_small;

  always_comb begin
    src_ok   = (fld.op1_src == 3'd0) || (fld.op1_src == 3'd1) ||
               (fld.op1_src == 3'd2) || (fld.op1_src == 3'd4);
    res_ok   = (fld.res_logic != 2'd3);
    pcu_ok   = (fld.pc_upd == 3'd0) || (fld.pc_upd == 3'd1) ||
               (fld.pc_upd == 3'd2) || (fld.pc_upd == 3'd4);
    apu_ok   = (fld.ap_upd != 2'd3);
    opc_ok   = (fld.opcode == 3'd0) || (fld.opcode == 3'd1) ||
               (fld.opcode == 3'd2) || (fld.opcode == 3'd4);
    ap_small = (fld.ap_upd == 2'd0) || (fld.ap_upd == 2'd2);

    imm_ok   = (fld.op1_src != 3'd1) || (fld.off_op1 == OFF_ONE);
    call_ok  = (fld.opcode != 3'd1) ||
               ((fld.off_dst == OFF_ZERO) && !fld.dst_fp &&
                (fld.off_op0 == OFF_ONE) && !fld.op0_fp &&
                (fld.ap_upd == 2'd0));
    ret_ok   = (fld.opcode != 3'd2) ||
               ((fld.off_dst == OFF_NEG2) && fld.dst_fp &&
                (fld.off_op1 == OFF_NEG1) && (fld.op1_src == 3'd2) &&
                (fld.res_logic == 2'd0) && (fld.pc_upd == 3'd1));
    hash_ok  = !((fld.ext == EXT_HASH) || (fld.ext == EXT_HFIN)) ||
               ((fld.opcode == 3'd0) &&
                ((fld.op1_src == 3'd2) || (fld.op1_src == 3'd4)) &&
                (fld.res_logic == 2'd0) && (fld.pc_upd == 3'd0) && ap_small);
    xar_ok   = (fld.ext != EXT_XAR) ||
               (((fld.res_logic == 2'd1) || (fld.res_logic == 2'd2)) &&
                (fld.op1_src != 3'd0) && (fld.pc_upd == 3'd0) && ap_small);
  end

  always_comb begin
    if (rsvd)          reason = RSN_RSVD;
    else if (!src_ok)  reason = RSN_SRC;
    else if (!res_ok)  reason = RSN_RES;
    else if (!pcu_ok)  reason = RSN_PCU;
    else if (!apu_ok)  reason = RSN_APU;
    else if (!opc_ok)  reason = RSN_OPC;
    else if (!imm_ok)  reason = RSN_IMM;
    else if (!call_ok) reason = RSN_CALL;
    else if (!ret_ok)  reason = RSN_RET;
    else if (!hash_ok) reason = RSN_HASH;
    else if (!xar_ok)  reason = RSN_XARITH;
    else               reason = RSN_OK;
  end
endmodule

// File: rtl/vm_dec_hold.sv
`timescale 1ns/1ps
module vm_dec_hold
  import vm_dec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  dec_t d,
  output logic out_valid,
  input  logic out_ready,
  output dec_t q
);
  logic vld_q, vld_d, load;
  dec_t dat_q, dat_d;

  always_comb begin
    in_ready = rst_n && (!vld_q || out_ready);
    load     = in_valid && in_ready;
    vld_d    = in_ready ? in_valid : (vld_q && rst_n);
    dat_d    = load ? d : dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load) dat_q <= dat_d;
  end

  assign out_valid = vld_q;
  assign q         = dat_q;
endmodule

// File: rtl/vm_insn_check.sv
`timescale 1ns/1ps
module vm_insn_check
  import vm_dec_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [WORD_W-1:0]       in_word,
  input  logic [EXT_W-1:0]        in_ext,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OFF_W-1:0] out_off_dst,
  output logic signed [OFF_W-1:0] out_off_op0,
  output logic signed [OFF_W-1:0] out_off_op1,
  output logic                    out_dst_fp,
  output logic                    out_op0_fp,
  output logic [2:0]              out_op1_src,
  output logic [1:0]              out_res_logic,
  output logic [2:0]              out_pc_upd,
  output logic [1:0]              out_ap_upd,
  output logic [2:0]              out_opcode,
  output logic [EXT_W-1:0]        out_ext,
  output logic [1:0]              out_size,
  output logic                    out_invalid,
  output logic [RSN_W-1:0]        out_reason
);
  logic    rst_sync_n;
  dec_t    fld, nxt, held;
  reason_e rsn;

  vm_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  vm_dec_fields i_fields (
    .word (in_word),
    .ext  (in_ext),
    .fld  (fld)
  );

  vm_dec_rules i_rules (
    .rsvd   (in_word[RSVD_BIT]),
    .fld    (fld),
    .reason (rsn)
  );

  always_comb begin
    nxt         = fld;
    nxt.reason  = rsn;
    nxt.invalid = (rsn != RSN_OK);
  end

  vm_dec_hold i_hold (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d         (nxt),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q         (held)
  );

  assign out_off_dst   = held.off_dst;
  assign out_off_op0   = held.off_op0;
  assign out_off_op1   = held.off_op1;
  assign out_dst_fp    = held.dst_fp;
  assign out_op0_fp    = held.op0_fp;
  assign out_op1_src   = held.op1_src;
  assign out_res_logic = held.res_logic;
  assign out_pc_upd    = held.pc_upd;
  assign out_ap_upd    = held.ap_upd;
  assign out_opcode    = held.opcode;
  assign out_ext       = held.ext;
  assign out_size      = held.size;
  assign out_invalid   = held.invalid;
  assign out_reason    = held.reason;
endmodule

// File: rtl/vm_insn_check_sva.sv
`timescale 1ns/1ps
module vm_insn_check_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_off_dst,
  input logic [15:0] out_off_op0,
  input logic [15:0] out_off_op1,
  input logic        out_dst_fp,
  input logic        out_op0_fp,
  input logic [2:0]  out_op1_src,
  input logic [1:0]  out_res_logic,
  input logic [2:0]  out_pc_upd,
  input logic [1:0]  out_ap_upd,
  input logic [2:0]  out_opcode,
  input logic [1:0]  out_ext,
  input logic [1:0]  out_size,
  input logic        out_invalid,
  input logic [3:0]  out_reason
);
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_off_dst, out_off_op0, out_off_op1, out_dst_fp, out_op0_fp,
               out_op1_src, out_res_logic, out_pc_upd, out_ap_upd, out_opcode,
               out_ext, out_size, out_invalid, out_reason}));

  p_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_take_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_invalid == (out_reason != 4'd0)));

  p_imm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_invalid && out_op1_src == 3'd1 |->
      out_off_op1 == 16'h0001 && out_size == 2'd2);

  p_call_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_invalid && out_opcode == 3'd1 |->
      out_off_dst == 16'h0000 && !out_dst_fp && out_off_op0 == 16'h0001 &&
      !out_op0_fp && out_ap_upd == 2'd0);

  p_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_invalid && out_opcode == 3'd2 |->
      out_off_dst == 16'hFFFE && out_dst_fp && out_off_op1 == 16'hFFFF &&
      out_op1_src == 3'd2 && out_res_logic == 2'd0 && out_pc_upd == 3'd1);

  p_hash_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_invalid && (out_ext == 2'd1 || out_ext == 2'd2) |->
      out_opcode == 3'd0 && out_res_logic == 2'd0 && out_pc_upd == 3'd0 &&
      out_ap_upd != 2'd1);

  p_xar_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_invalid && out_ext == 2'd3 |->
      out_res_logic != 2'd0 && out_op1_src != 3'd0 && out_pc_upd == 3'd0 &&
      out_ap_upd != 2'd1);
endmodule

bind vm_insn_check vm_insn_check_sva i_sva (.*);

// File: tb/test_vm_insn_check.sv
`timescale 1ns/1ps
module test_vm_insn_check;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_word;
  logic [1:0]  in_ext;
  logic        out_valid;
  logic        out_ready;
  logic signed [15:0] out_off_dst, out_off_op0, out_off_op1;
  logic        out_dst_fp, out_op0_fp;
  logic [2:0]  out_op1_src, out_pc_upd, out_opcode;
  logic [1:0]  out_res_logic, out_ap_upd, out_ext, out_size;
  logic        out_invalid;
  logic [3:0]  out_reason;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  bit          m_valid = 0;
  logic [63:0] m_word  = '0;
  logic [1:0]  m_ext   = '0;

  always #2.5 clk = ~clk;

  vm_insn_check i_vm_insn_check (.*);

  task automatic chk(string req, string what, longint act, longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(int od, int o0, int o1, bit dr, bit r0,
                                     int src, int res, int pc, int ap, int opc, bit b63);
    logic [63:0] w;
    w[15:0]  = 16'(od + 32768);
    w[31:16] = 16'(o0 + 32768);
    w[47:32] = 16'(o1 + 32768);
    w[48]    = dr;
    w[49]    = r0;
    w[52:50] = 3'(src);
    w[54:53] = 2'(res);
    w[57:55] = 3'(pc);
    w[59:58] = 2'(ap);
    w[62:60] = 3'(opc);
    w[63]    = b63;
    return w;
  endfunction

  function automatic int ref_reason(logic [63:0] w, logic [1:0] e);
    int od, o0, o1, src, res, pc, ap, opc;
    bit dr;
    od = int'(w[15:0]) - 32768;  o0 = int'(w[31:16]) - 32768;
    o1 = int'(w[47:32]) - 32768; dr = w[48];
    src = int'(w[52:50]); res = int'(w[54:53]); pc = int'(w[57:55]);
    ap = int'(w[59:58]);  opc = int'(w[62:60]);
    if (w[63]) return 1;
    if (!(src == 0 || src == 1 || src == 2 || src == 4)) return 2;
    if (res > 2) return 3;
    if (!(pc == 0 || pc == 1 || pc == 2 || pc == 4)) return 4;
    if (ap > 2) return 5;
    if (!(opc == 0 || opc == 1 || opc == 2 || opc == 4)) return 6;
    if (src == 1 && o1 != 1) return 7;
    if (opc == 1 && !(od == 0 && !dr && o0 == 1 && !w[49] && ap == 0)) return 8;
    if (opc == 2 && !(od == -2 && dr && o1 == -1 && src == 2 && res == 0 && pc == 1)) return 9;
    if ((e == 1 || e == 2) && !(opc == 0 && (src == 2 || src == 4) && res == 0 &&
                               pc == 0 && (ap == 0 || ap == 2))) return 10;
    if (e == 3 && !((res == 1 || res == 2) && src != 0 && pc == 0 &&
                    (ap == 0 || ap == 2))) return 11;
    return 0;
  endfunction

  function automatic string rtag(int r);
    case (r)
      0: return "R11";
      1: return "R4";
      2, 3, 4, 5, 6: return "R5";
      7: return "R6";
      8: return "R7";
      9: return "R8";
      10: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic compare();
    int r;
    chk("R12", "out_valid", out_valid, m_valid);
    if (m_valid) begin
      r = ref_reason(m_word, m_ext);
      chk("R1", "off_dst", int'(out_off_dst), int'(m_word[15:0]) - 32768);
      chk("R1", "off_op0", int'(out_off_op0), int'(m_word[31:16]) - 32768);
      chk("R1", "off_op1", int'(out_off_op1), int'(m_word[47:32]) - 32768);
      chk("R2", "flags", {out_dst_fp, out_op0_fp, out_op1_src, out_res_logic,
                          out_pc_upd, out_ap_upd, out_opcode, out_ext},
          {m_word[48], m_word[49], m_word[52:50], m_word[54:53],
           m_word[57:55], m_word[59:58], m_word[62:60], m_ext});
      chk("R3", "size", out_size, (m_word[52:50] == 3'd1) ? 2 : 1);
      chk(rtag(r), "reason", out_reason, r);
      chk("R11", "invalid", out_invalid, r != 0);
    end
  endtask

  task automatic cycle(bit v, logic [63:0] w, logic [1:0] e, bit rdy);
    bit mrdy;
    @(negedge clk);
    compare();
    in_valid = v; in_word = w; in_ext = e; out_ready = rdy;
    #0.5;
    mrdy = !m_valid || rdy;
    chk("R12", "in_ready", in_ready, mrdy);
    if (mrdy) begin
      m_valid = v;
      if (v) begin m_word = w; m_ext = e; end
    end
  endtask

  task automatic send(logic [63:0] w, logic [1:0] e);
    cycle(1'b1, w, e, 1'b1);
  endtask

  initial begin
    in_valid = 0; in_word = '0; in_ext = '0; out_ready = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R13", "out_valid in reset", out_valid, 0);
    chk("R13", "in_ready in reset", in_ready, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R13", "in_ready during release", in_ready, 0);
    repeat (2) @(negedge clk);

    // legal forms (R1 R2 R3 R11)
    send(mk(3, -1, 5, 0, 1, 2, 1, 0, 2, 4, 0), 2'd0);
    send(mk(0, 1, 1, 0, 0, 1, 0, 2, 0, 1, 0), 2'd0);        // call, imm, size 2
    send(mk(-2, -1, -1, 1, 1, 2, 0, 1, 0, 2, 0), 2'd0);     // ret
    send(mk(-32768, 32767, 0, 1, 0, 4, 2, 4, 1, 0, 0), 2'd0); // R10: ext 0 no rules
    // R7 call faults
    send(mk(0, 1, 1, 0, 0, 1, 0, 2, 2, 1, 0), 2'd0);
    send(mk(0, 1, 3, 1, 0, 2, 0, 0, 0, 1, 0), 2'd0);
    send(mk(0, 2, 3, 0, 0, 2, 0, 0, 0, 1, 0), 2'd0);
    // R8 ret faults
    send(mk(-2, -1, -1, 1, 1, 2, 1, 1, 0, 2, 0), 2'd0);
    send(mk(-2, -1, -1, 0, 1, 2, 0, 1, 0, 2, 0), 2'd0);
    send(mk(-2, -1, -2, 1, 1, 2, 0, 1, 0, 2, 0), 2'd0);
    // R4 with other faults
    send(mk(0, 0, 0, 0, 0, 3, 3, 3, 3, 7, 1), 2'd3);
    send(mk(0, 0, 0, 0, 0, 2, 0, 0, 0, 0, 1), 2'd0);
    // R5 order
    send(mk(0, 0, 0, 0, 0, 3, 3, 0, 0, 0, 0), 2'd0);
    send(mk(0, 0, 0, 0, 0, 5, 0, 0, 0, 0, 0), 2'd0);
    send(mk(0, 0, 0, 0, 0, 0, 3, 5, 0, 0, 0), 2'd0);
    send(mk(0, 0, 0, 0, 0, 0, 0, 3, 3, 0, 0), 2'd0);
    send(mk(0, 0, 0, 0, 0, 0, 0, 0, 3, 3, 0), 2'd0);
    send(mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 6, 0), 2'd0);
    send(mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 3, 0), 2'd3);
    // R6 immediate
    send(mk(0, 0, 2, 0, 0, 1, 0, 0, 0, 4, 0), 2'd0);
    send(mk(5, 1, 0, 1, 0, 1, 0, 0, 0, 1, 0), 2'd0);        // also bad call
    // R9 hash extensions
    send(mk(0, 0, 0, 0, 0, 2, 0, 0, 2, 0, 0), 2'd1);
    send(mk(0, 0, 0, 0, 0, 4, 0, 0, 0, 0, 0), 2'd2);
    send(mk(0, 0, 0, 0, 0, 2, 0, 0, 0, 4, 0), 2'd1);
    send(mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), 2'd2);
    send(mk(0, 0, 0, 0, 0, 4, 0, 0, 1, 0, 0), 2'd1);
    // R10 extension arithmetic
    send(mk(0, 0, 0, 0, 0, 4, 2, 0, 0, 4, 0), 2'd3);
    send(mk(0, 0, 0, 0, 0, 4, 0, 0, 0, 4, 0), 2'd3);
    send(mk(0, 0, 0, 0, 0, 0, 1, 0, 2, 4, 0), 2'd3);
    send(mk(0, 0, 0, 0, 0, 2, 1, 2, 0, 0, 0), 2'd3);

    // R12 stall with a new word waiting, then release
    send(mk(7, 7, 7, 1, 1, 2, 1, 0, 2, 4, 0), 2'd0);
    for (int k = 0; k < 4; k++) cycle(1'b1, mk(9, 9, 9, 0, 0, 4, 2, 0, 0, 4, 0), 2'd0, 1'b0);
    cycle(1'b1, mk(9, 9, 9, 0, 0, 4, 2, 0, 0, 4, 0), 2'd0, 1'b1);
    cycle(1'b0, '0, '0, 1'b0);
    cycle(1'b0, '0, '0, 1'b1);

    // random mix with back-pressure
    for (int k = 0; k < 4000; k++) begin
      logic [63:0] w;
      if ($urandom_range(0, 1) == 0) w = {$urandom, $urandom};
      else w = mk(int'($urandom_range(0, 4)) - 2, int'($urandom_range(0, 3)) - 1,
                  int'($urandom_range(0, 3)) - 1, 1'($urandom), 1'($urandom),
                  int'($urandom_range(0, 4)), int'($urandom_range(0, 2)),
                  int'($urandom_range(0, 4)), int'($urandom_range(0, 2)),
                  int'($urandom_range(0, 4)), ($urandom_range(0, 15) == 0));
      cycle($urandom_range(0, 9) < 6, w, 2'($urandom), $urandom_range(0, 9) < 7);
    end
    @(negedge clk);
    compare();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule